// File: doc/BRIEF.md
# Split Virtqueue Consumer Engine

This engine services one split virtqueue on behalf of a device. A one-cycle notify pulse starts a pass. The engine reads the driver's ring header through a simple memory master port. It then walks every ring entry the driver has published since the previous pass. For each entry it loads the 16-byte descriptor named by that entry and offers the buffer address and length to a consumer. It then records the consumed byte count in the used ring.

When the walk ends, the engine publishes its running index in the used ring, but only if the pass produced at least one element. It raises an interrupt pulse unless the driver has asked for interrupts to be suppressed. A pass ends early on three conditions: an out-of-range descriptor number, an empty descriptor, or a consumer that takes nothing. The entry that stopped the pass stays pending, and the next notify retries it. Chained and indirect descriptors are not followed, and the engine never touches the payload.

Top module: `vq_consumer`

## Requirements
- R1: A notify pulse seen while `busy` is low starts a pass, and `busy` is high from the next cycle until the pass ends. The first access of a pass is one 32-bit read at `avail_base`, in which bits 15:0 hold the driver flags and bits 31:16 hold the driver's available index. A notify pulse while `busy` is high has no effect.
- R2: The engine keeps a 16-bit running index that persists across passes and starts at 0 after reset. It services entries while this index differs from the available index, and it adds one for each entry that completes.
- R3: The ring slot is the running index modulo `qsize`. The ring entry is a 16-bit read at `avail_base + 4 + 2*slot`.
- R4: For descriptor number `d`, the engine reads the 64-bit address at `desc_base + 16*d` and the 32-bit length at `desc_base + 16*d + 8`. It presents both on `cons_addr`/`cons_len` with `cons_valid` held high until `cons_done`, and it takes the consumed count from `cons_used` in the `cons_done` cycle.
- R5: A descriptor number not below `qsize` ends the pass without a consumer call and without advancing the index.
- R6: A descriptor with a zero address or a zero length, or a consumed count of zero, ends the pass. The index does not advance, no used element is written, and the entry is retried on the next notify.
- R7: Each completed entry writes one 64-bit used element at `used_base + 4 + 8*slot`. Bits 31:0 of the element hold the descriptor number and bits 63:32 hold the consumed count.
- R8: If a pass wrote at least one element, the running index is written as a 16-bit value to `used_base + 2`, after every element write of that pass. A pass that wrote no element makes no write there.
- R9: `irq` pulses for one cycle at the end of a pass if and only if at least one element was written and bit 0 of the driver flags read at the start of that pass is 0.
- R10: The memory port holds `mem_req`, `mem_we`, `mem_size` and `mem_addr` stable until `mem_ack`. `mem_size` codes 0, 1 and 2 select 16, 32 and 64 bits. Data are little-endian and right-aligned in `mem_wdata`/`mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| notify | input | 1 | Start-of-pass pulse |
| qsize | input | QSZ_W | Queue size in entries |
| desc_base | input | ADDR_W | Descriptor table base address |
| avail_base | input | ADDR_W | Driver (available) ring base address |
| used_base | input | ADDR_W | Device (used) ring base address |
| busy | output | 1 | Pass in progress |
| irq | output | 1 | One-cycle interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size code |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 64 | Read data |
| cons_valid | output | 1 | Buffer offered to consumer |
| cons_addr | output | 64 | Buffer address |
| cons_len | output | 32 | Buffer length in bytes |
| cons_done | input | 1 | Consumer finished with buffer |
| cons_used | input | 32 | Bytes consumed |

## Verification
The bench builds the engine with `ADDR_W` = 16 and `qsize` = 6. A non-power-of-two queue size means slot arithmetic uses a true modulo rather than a bit mask. Descriptor number 6 is then the smallest out-of-range value. Over a few passes the running index crosses several slot wraps, so element placement after a wrap is checked. Descriptor addresses carry nonzero upper 32 bits, so the full 64-bit address path reaches the consumer.

// File: rtl/vq_pkg.sv
package vq_pkg;
    localparam int RIDX_W = 16;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_32 = 2'd1,
        SZ_64 = 2'd2
    } msize_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_AVAIL, S_CHECK, S_RD_RING, S_RD_DADDR,
        S_RD_DLEN, S_CONSUME, S_WR_ELEM, S_FINISH, S_WR_IDX, S_DONE
    } st_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] len;
    } desc_t;

    typedef struct packed {
        logic [31:0] used_len;
        logic [31:0] id;
    } used_elem_t;

    function automatic logic [RIDX_W-1:0] slot_of(input logic [RIDX_W-1:0] idx,
                                                   input logic [RIDX_W-1:0] qs);
        return (qs == '0) ? '0 : idx % qs;
    endfunction
endpackage

// File: rtl/vq_cursor.sv
module vq_cursor
    import vq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic [RIDX_W-1:0] avail_idx,
    output logic [RIDX_W-1:0] cur_idx,
    output logic              pending
);
    always_ff @(posedge clk) begin
        if (rst)      cur_idx <= '0;
        else if (inc) cur_idx <= cur_idx + 1'b1;
    end

    assign pending = (cur_idx != avail_idx);

    // R2: the index only advances on an entry that was still outstanding
    assert_adv_only_pending_R2: assert property (@(posedge clk) disable iff (rst)
        inc |-> pending);
endmodule

// File: rtl/vq_addr_calc.sv
module vq_addr_calc
    import vq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int QSZ_W  = 10
) (
    input  st_e               st,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [ADDR_W-1:0] avail_base,
    input  logic [ADDR_W-1:0] used_base,
    input  logic [RIDX_W-1:0] cur_idx,
    input  logic [RIDX_W-1:0] desc_id,
    input  logic [QSZ_W-1:0]  qsize,
    output logic [ADDR_W-1:0] addr,
    output msize_e            size,
    output logic              we
);
    logic [RIDX_W-1:0] slot;

    assign slot = slot_of(cur_idx, RIDX_W'(qsize));

    always_comb begin
        addr = '0;
        size = SZ_16;
        we   = 1'b0;
        case (st)
            S_RD_AVAIL: begin
                addr = avail_base;
                size = SZ_32;
            end
            S_RD_RING: begin
                addr = avail_base + ADDR_W'(4) + ADDR_W'({slot, 1'b0});
                size = SZ_16;
            end
            S_RD_DADDR: begin
                addr = desc_base + ADDR_W'({desc_id, 4'b0000});
                size = SZ_64;
            end
            S_RD_DLEN: begin
                addr = desc_base + ADDR_W'({desc_id, 4'b0000}) + ADDR_W'(8);
                size = SZ_32;
            end
            S_WR_ELEM: begin
                addr = used_base + ADDR_W'(4) + ADDR_W'({slot, 3'b000});
                size = SZ_64;
                we   = 1'b1;
            end
            S_WR_IDX: begin
                addr = used_base + ADDR_W'(2);
                size = SZ_16;
                we   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vq_consumer.sv
module vq_consumer
    import vq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int QSZ_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              notify,
    input  logic [QSZ_W-1:0]  qsize,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [ADDR_W-1:0] avail_base,
    input  logic [ADDR_W-1:0] used_base,
    output logic              busy,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              cons_valid,
    output logic [63:0]       cons_addr,
    output logic [31:0]       cons_len,
    input  logic              cons_done,
    input  logic [31:0]       cons_used
);
    st_e               st;
    logic [RIDX_W-1:0] avail_idx;
    logic [RIDX_W-1:0] cur_idx;
    logic [RIDX_W-1:0] desc_id;
    logic              pending;
    logic              no_irq;
    logic              wrote;
    logic [31:0]       used_len;
    desc_t             desc;
    used_elem_t        elem;
    msize_e            acc_size;

    vq_cursor u_cursor (
        .clk       (clk),
        .rst       (rst),
        .inc       (st == S_WR_ELEM && mem_ack),
        .avail_idx (avail_idx),
        .cur_idx   (cur_idx),
        .pending   (pending)
    );

    vq_addr_calc #(.ADDR_W(ADDR_W), .QSZ_W(QSZ_W)) u_addr (
        .st         (st),
        .desc_base  (desc_base),
        .avail_base (avail_base),
        .used_base  (used_base),
        .cur_idx    (cur_idx),
        .desc_id    (desc_id),
        .qsize      (qsize),
        .addr       (mem_addr),
        .size       (acc_size),
        .we         (mem_we)
    );

    assign mem_size = acc_size;
    assign mem_req  = (st == S_RD_AVAIL) || (st == S_RD_RING) || (st == S_RD_DADDR) ||
                      (st == S_RD_DLEN)  || (st == S_WR_ELEM) || (st == S_WR_IDX);
    assign busy       = (st != S_IDLE);
    assign cons_valid = (st == S_CONSUME);
    assign cons_addr  = desc.addr;
    assign cons_len   = desc.len;

    assign elem.used_len = used_len;
    assign elem.id       = 32'(desc_id);
    assign mem_wdata     = (st == S_WR_IDX) ? 64'(cur_idx) : elem;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            avail_idx <= '0;
            desc_id   <= '0;
            no_irq    <= 1'b0;
            wrote     <= 1'b0;
            used_len  <= '0;
            desc      <= '0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (st)
                S_IDLE: if (notify) begin
                    wrote <= 1'b0;
                    st    <= S_RD_AVAIL;
                end
                S_RD_AVAIL: if (mem_ack) begin
                    no_irq    <= mem_rdata[0];
                    avail_idx <= mem_rdata[31:16];
                    st        <= S_CHECK;
                end
                S_CHECK: st <= pending ? S_RD_RING : S_FINISH;
                S_RD_RING: if (mem_ack) begin
                    desc_id <= mem_rdata[RIDX_W-1:0];
                    st <= (mem_rdata[RIDX_W-1:0] >= RIDX_W'(qsize)) ? S_FINISH : S_RD_DADDR;
                end
                S_RD_DADDR: if (mem_ack) begin
                    desc.addr <= mem_rdata;
                    st        <= S_RD_DLEN;
                end
                S_RD_DLEN: if (mem_ack) begin
                    desc.len <= mem_rdata[31:0];
                    st <= (desc.addr == '0 || mem_rdata[31:0] == '0) ? S_FINISH : S_CONSUME;
                end
                S_CONSUME: if (cons_done) begin
                    used_len <= cons_used;
                    st <= (cons_used == '0) ? S_FINISH : S_WR_ELEM;
                end
                S_WR_ELEM: if (mem_ack) begin
                    wrote <= 1'b1;
                    st    <= S_CHECK;
                end
                S_FINISH: st <= wrote ? S_WR_IDX : S_DONE;
                S_WR_IDX: if (mem_ack) st <= S_DONE;
                S_DONE: begin
                    irq <= wrote && !no_irq;
                    st  <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10: an access stays unchanged until it is acknowledged
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_size)));
    // R1: a pass begins only on a notify pulse
    assert_start_on_notify_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(notify));
    // R4: the offer to the consumer is held until it completes
    assert_cons_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cons_valid && !cons_done) |=> (cons_valid && $stable(cons_addr) && $stable(cons_len)));
    // R5: the consumer is never offered an out-of-range descriptor
    assert_cons_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        cons_valid |-> (desc_id < RIDX_W'(qsize)));
    // R9: the interrupt is a single-cycle pulse outside any pass
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
endmodule

// File: tb/tb_vq_consumer.sv
module tb_vq_consumer;
    localparam int ADDR_W = 16;
    localparam int QSZ_W  = 10;
    localparam int QS     = 6;
    localparam logic [11:0] DESC_B  = 12'h100;
    localparam logic [11:0] AVAIL_B = 12'h400;
    localparam logic [11:0] USED_B  = 12'h600;

    // row: {new entries [3:0], no-interrupt flag, expected irq}
    localparam logic [5:0] VEC [4] = '{
        {4'd3, 1'b0, 1'b1},
        {4'd2, 1'b1, 1'b0},
        {4'd4, 1'b0, 1'b1},
        {4'd0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic notify = 1'b0;
    logic busy, irq, mem_req, mem_we, mem_ack, cons_valid, cons_done;
    logic [1:0]        mem_size;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_wdata, mem_rdata, cons_addr;
    logic [31:0]       cons_len, cons_used;

    logic [7:0] mem [0:4095];
    logic        poke_en = 1'b0;
    logic [11:0] poke_addr = '0;
    logic [15:0] poke_data = '0;
    logic        zero_mode = 1'b0;

    int n_avail_rd = 0, n_elem_wr = 0, n_idx_wr = 0, elem_at_idx = 0;
    int n_cons = 0, n_irq = 0;
    logic [63:0] log_addr [0:31];
    logic [31:0] log_len  [0:31];

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    vq_consumer #(.ADDR_W(ADDR_W), .QSZ_W(QSZ_W)) dut (
        .clk(clk), .rst(rst), .notify(notify), .qsize(QSZ_W'(QS)),
        .desc_base(ADDR_W'(DESC_B)), .avail_base(ADDR_W'(AVAIL_B)), .used_base(ADDR_W'(USED_B)),
        .busy(busy), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cons_valid(cons_valid), .cons_addr(cons_addr), .cons_len(cons_len),
        .cons_done(cons_done), .cons_used(cons_used)
    );

    // memory model: one access served per request, acknowledged one cycle later
    always @(posedge clk) begin
        logic [11:0] a;
        mem_ack <= 1'b0;
        if (poke_en) begin
            mem[poke_addr]         <= poke_data[7:0];
            mem[poke_addr + 12'd1] <= poke_data[15:8];
        end
        if (rst) begin
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            a = mem_addr[11:0];
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (b < (2 << mem_size)) mem[a + 12'(b)] <= mem_wdata[8*b +: 8];
                if (a == USED_B + 12'd2) begin
                    n_idx_wr    <= n_idx_wr + 1;
                    elem_at_idx <= n_elem_wr;
                end else begin
                    n_elem_wr <= n_elem_wr + 1;
                end
            end else begin
                for (int b = 0; b < 8; b++) mem_rdata[8*b +: 8] <= mem[a + 12'(b)];
                if (a == AVAIL_B) n_avail_rd <= n_avail_rd + 1;
            end
        end
    end

    // consumer model
    always @(posedge clk) begin
        cons_done <= 1'b0;
        if (rst) begin
            cons_used <= '0;
        end else if (cons_valid && !cons_done) begin
            cons_done <= 1'b1;
            cons_used <= zero_mode ? 32'd0 : cons_len - 32'd1;
            log_addr[n_cons % 32] <= cons_addr;
            log_len[n_cons % 32]  <= cons_len;
            n_cons <= n_cons + 1;
        end
    end

    always @(posedge clk) if (irq) n_irq <= n_irq + 1;

    function automatic logic [31:0] rd32(input logic [11:0] a);
        return {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
    endfunction

    function automatic logic [15:0] rd16(input logic [11:0] a);
        return {mem[a + 12'd1], mem[a]};
    endfunction

    function automatic logic [63:0] d_addr(input int id);
        return 64'h1_0000_0000 + 64'(id) * 64'h1000;
    endfunction

    function automatic logic [31:0] d_len(input int id);
        return 32'h40 + 32'(id);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic poke16(input logic [11:0] a, input logic [15:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_desc(input int id, input logic [63:0] ad, input logic [31:0] ln);
        for (int w = 0; w < 4; w++) poke16(DESC_B + 12'(16*id + 2*w), ad[16*w +: 16]);
        poke16(DESC_B + 12'(16*id + 8), ln[15:0]);
        poke16(DESC_B + 12'(16*id + 10), ln[31:16]);
    endtask

    task automatic run_pass(input bit extra_notify);
        int t;
        @(negedge clk); notify = 1'b1;
        @(negedge clk); notify = 1'b0;
        if (extra_notify) begin
            repeat (3) @(negedge clk);
            notify = 1'b1;
            @(negedge clk); notify = 1'b0;
        end
        t = 0;
        while (busy && t < 5000) begin
            @(negedge clk); t++;
        end
        if (busy) begin
            errors++;
            $display("FAIL watchdog: pass did not end");
        end
        repeat (3) @(negedge clk);
    endtask

    int drv_idx = 0;
    int k_glob = 0;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        for (int i = 0; i < QS; i++) set_desc(i, d_addr(i), d_len(i));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R9", "irq after reset", irq, 0);
        chk("R10", "mem_req after reset", mem_req, 0);
        chk("R4", "cons_valid after reset", cons_valid, 0);

        // table-driven passes
        for (int r = 0; r < 4; r++) begin
            int n, nint, eirq, b_cons, b_elem, b_idx, b_irq, start;
            n = int'(VEC[r][5:2]); nint = int'(VEC[r][1]); eirq = int'(VEC[r][0]);
            b_cons = n_cons; b_elem = n_elem_wr; b_idx = n_idx_wr; b_irq = n_irq;
            start = drv_idx;
            for (int k = 0; k < n; k++) begin
                poke16(AVAIL_B + 12'd4 + 12'(2 * (drv_idx % QS)), 16'((5 * k_glob + 2) % QS));
                drv_idx++; k_glob++;
            end
            poke16(AVAIL_B, 16'(nint));
            poke16(AVAIL_B + 12'd2, 16'(drv_idx));
            run_pass(1'b0);
            chk("R2", "consumer calls", n_cons - b_cons, n);
            chk("R7", "element writes", n_elem_wr - b_elem, n);
            chk("R8", "index writes", n_idx_wr - b_idx, (n > 0) ? 1 : 0);
            if (n > 0) begin
                chk("R8", "used index", rd16(USED_B + 12'd2), drv_idx);
                chk("R8", "elements before index", elem_at_idx - b_elem, n);
            end
            chk("R9", "irq count", n_irq - b_irq, eirq);
            for (int k = 0; k < n; k++) begin
                int slot, id;
                slot = (start + k) % QS;
                id   = int'(rd16(AVAIL_B + 12'd4 + 12'(2 * slot)));
                chk("R3", "element id at slot", rd32(USED_B + 12'd4 + 12'(8 * slot)), id);
                chk("R7", "element length (R10 little-endian)",
                    rd32(USED_B + 12'd8 + 12'(8 * slot)), d_len(id) - 1);
                chk("R4", "consumer address", log_addr[(b_cons + k) % 32], d_addr(id));
                chk("R4", "consumer length", log_len[(b_cons + k) % 32], d_len(id));
            end
        end

        // notify during a pass is ignored
        begin
            int b_rd, b_cons;
            b_rd = n_avail_rd; b_cons = n_cons;
            poke16(AVAIL_B + 12'd4 + 12'(2 * (drv_idx % QS)), 16'd1);
            drv_idx++;
            poke16(AVAIL_B + 12'd2, 16'(drv_idx));
            run_pass(1'b1);
            repeat (10) @(negedge clk);
            chk("R1", "header reads with extra notify", n_avail_rd - b_rd, 1);
            chk("R1", "busy stays low", busy, 0);
            chk("R1", "one consumer call", n_cons - b_cons, 1);
        end

        // out-of-range descriptor after a valid one, then repair
        begin
            int b_cons, b_irq, b_idx;
            b_cons = n_cons; b_irq = n_irq; b_idx = n_idx_wr;
            poke16(AVAIL_B + 12'd4 + 12'(2 * (drv_idx % QS)), 16'd2);
            drv_idx++;
            poke16(AVAIL_B + 12'd4 + 12'(2 * (drv_idx % QS)), 16'(QS));
            drv_idx++;
            poke16(AVAIL_B + 12'd2, 16'(drv_idx));
            run_pass(1'b0);
            chk("R5", "consumer calls before abort", n_cons - b_cons, 1);
            chk("R5", "used index stops at bad entry", rd16(USED_B + 12'd2), drv_idx - 1);
            chk("R8", "index written after partial pass", n_idx_wr - b_idx, 1);
            chk("R9", "irq after partial pass", n_irq - b_irq, 1);
            poke16(AVAIL_B + 12'd4 + 12'(2 * ((drv_idx - 1) % QS)), 16'd4);
            b_cons = n_cons;
            run_pass(1'b0);
            chk("R5", "retry of repaired entry", n_cons - b_cons, 1);
            chk("R5", "used index after retry", rd16(USED_B + 12'd2), drv_idx);
        end

        // zero-length descriptor stops the pass and is retried
        begin
            int b_cons, b_idx, b_irq;
            set_desc(3, d_addr(3), 32'd0);
            poke16(AVAIL_B + 12'd4 + 12'(2 * (drv_idx % QS)), 16'd3);
            drv_idx++;
            poke16(AVAIL_B + 12'd2, 16'(drv_idx));
            b_cons = n_cons; b_idx = n_idx_wr; b_irq = n_irq;
            run_pass(1'b0);
            chk("R6", "no consumer call on empty descriptor", n_cons - b_cons, 0);
            chk("R6", "no index write on empty descriptor", n_idx_wr - b_idx, 0);
            chk("R9", "no irq without elements", n_irq - b_irq, 0);
            set_desc(3, d_addr(3), d_len(3));
            run_pass(1'b0);
            chk("R6", "empty entry retried", n_cons - b_cons, 1);
            chk("R6", "used index after retry", rd16(USED_B + 12'd2), drv_idx);
        end

        // consumer takes nothing
        begin
            int b_cons, b_elem, b_idx;
            zero_mode = 1'b1;
            poke16(AVAIL_B + 12'd4 + 12'(2 * (drv_idx % QS)), 16'd5);
            drv_idx++;
            poke16(AVAIL_B + 12'd2, 16'(drv_idx));
            b_cons = n_cons; b_elem = n_elem_wr; b_idx = n_idx_wr;
            run_pass(1'b0);
            chk("R6", "consumer was called", n_cons - b_cons, 1);
            chk("R6", "no element on zero consumed", n_elem_wr - b_elem, 0);
            chk("R6", "no index write on zero consumed", n_idx_wr - b_idx, 0);
            zero_mode = 1'b0;
            run_pass(1'b0);
            chk("R6", "element after retry", n_elem_wr - b_elem, 1);
            chk("R2", "index after retry", rd16(USED_B + 12'd2), drv_idx);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule